// File: doc/BRIEF.md
# Bridge Delayed-Completion Discard Timer

This block keeps one discard timer for each side of a PCI-to-PCI bridge: index 0 serves the primary interface and index 1 the secondary. A timer is armed when the bridge queues a delayed completion for that interface. It is disarmed when the original requester returns and takes the completion. If nobody takes the completion before the timer runs out, the block emits a one-cycle discard pulse for that interface. The queueing logic uses this pulse to drop the stale completion.

A 16-bit bridge control word sets the behaviour and records timeouts. Software reads and writes it through a single-cycle register port. Bits 8 and 9 pick a long or a short period for the primary and secondary timer. Bit 10 is a sticky timeout flag that software clears by writing 1 to it. Bit 11 lets a timeout raise a one-cycle system error request toward the primary bus. The other defined bits are plain storage that neighbouring logic decodes. The periods are 2^LONG_LOG2 and 2^SHORT_LOG2 clock cycles, with defaults of 2^15 and 2^10.

Top module: `dtx_discard_ctl`

## Requirements
- R1: After synchronous reset, `reg_rdata_o` reads 0x0000, `discard_o` and `serr_o` are 0, and no discard appears without a new queue pulse.
- R2: For the primary timer (index 0), control bit 8 = 0 gives a period N = 2^LONG_LOG2 and bit 8 = 1 gives N = 2^SHORT_LOG2. With no claim, `discard_o[0]` is high in the cycle that follows the N-th clock edge after the edge that sampled `cpl_queued_i[0]`.
- R3: The secondary timer (index 1) behaves the same way, with control bit 9 selecting its period.
- R4: A claim pulse sampled at any edge from the 1st through the N-th edge after the queue edge cancels the timer, and no discard follows. A claim on the same edge as expiry wins.
- R5: A queue pulse while the timer runs restarts the full period from that edge.
- R6: Each expiry produces exactly one single-cycle discard pulse.
- R7: Control bit 10 becomes 1 on the edge that samples any discard pulse and then holds until it is cleared.
- R8: Writing 1 to bit 10 clears it and writing 0 leaves it unchanged. If a discard is sampled on the same edge as a write of 1, the bit stays 1.
- R9: When bit 11 is 1, `serr_o` pulses for one cycle in the cycle after a discard pulse. When bit 11 is 0 there is no pulse. Discards on both interfaces in the same cycle give one pulse.
- R10: Bits 0, 1, 2, 3, 5, 6, 7, 8, 9 and 11 store the written value from the edge that samples the write. Bits 4 and 12 to 15 always read 0.
- R11: The period is taken from bit 8 or bit 9 at the queue edge. Changing the bit while the timer runs does not alter the running count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 16 | Write data for the control word |
| reg_rdata_o | output | 16 | Current control word |
| cpl_queued_i | input | 2 | Completion-queued pulse per interface (0 primary, 1 secondary) |
| cpl_claimed_i | input | 2 | Completion-claimed pulse per interface |
| discard_o | output | 2 | One-cycle discard pulse per interface |
| serr_o | output | 1 | One-cycle system error request |

## Verification
Two functions can land on the same clock edge. The first pair is the hardware setting the sticky timeout flag and a software write that clears it. The bench sets this up by placing the write-one strobe exactly on the edge that samples a discard pulse, then reads bit 10 back and expects it still set. The second pair is a claim and an expiry on the same edge: a claim offset sweep runs past the expiry edge, so the claim lands exactly on it, and the bench expects no discard there and a discard at every later offset.

// File: rtl/dtx_pkg.sv
package dtx_pkg;
  localparam int NUM_IF       = 2;
  localparam int IF_PRI       = 0;
  localparam int IF_SEC       = 1;
  localparam int CTL_W        = 16;
  // control word bit positions decoded by neighbouring logic
  localparam int BC_PRI_SHORT = 8;
  localparam int BC_SEC_SHORT = 9;
  localparam int BC_STATUS    = 10;
  localparam int BC_SERR_EN   = 11;
  // plain storage bits: 0,1,2,3,5,6,7 plus the period selects and error enable
  localparam logic [CTL_W-1:0] RW_MASK = 16'h0BEF;

  typedef logic [CTL_W-1:0] bctl_t;
endpackage

// File: rtl/dtx_timer.sv
module dtx_timer #(
  parameter int LONG_LOG2  = 15,
  parameter int SHORT_LOG2 = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic queued_i,
  input  logic claimed_i,
  input  logic short_sel_i,
  output logic discard_o
);
  localparam int CW = LONG_LOG2;
  localparam logic [CW-1:0] LOAD_LONG  = {CW{1'b1}};
  localparam logic [CW-1:0] LOAD_SHORT = CW'((32'd1 << SHORT_LOG2) - 32'd1);

  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          disc_q;
  logic          expire;

  // a new queue pulse or a claim takes priority over expiry on the same edge
  assign expire = run_q && (cnt_q == '0) && !claimed_i && !queued_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      run_q  <= 1'b0;
      disc_q <= 1'b0;
    end else begin
      disc_q <= expire;
      if (queued_i) begin
        run_q <= 1'b1;
        cnt_q <= short_sel_i ? LOAD_SHORT : LOAD_LONG;
      end else if (claimed_i) begin
        run_q <= 1'b0;
      end else if (run_q) begin
        if (cnt_q == '0) run_q <= 1'b0;
        else             cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign discard_o = disc_q;

  // R4: a claim on any edge leaves the next cycle free of discard
  p_claim_cancels_r4: assert property (@(posedge clk) disable iff (rst)
    claimed_i |=> !discard_o);
  // R6: a discard never lasts longer than one cycle
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    discard_o |=> !discard_o);
  // R2: a discard only follows a cycle in which the timer was armed
  p_discard_armed_r2: assert property (@(posedge clk) disable iff (rst)
    discard_o |-> $past(run_q));
  // R5: a queue pulse arms the timer and suppresses any discard next cycle
  p_reload_r5: assert property (@(posedge clk) disable iff (rst)
    queued_i |=> (run_q && !discard_o));
endmodule

// File: rtl/dtx_ctrl_reg.sv
module dtx_ctrl_reg
  import dtx_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  bctl_t             wdata_i,
  input  logic [NUM_IF-1:0] disc_i,
  output bctl_t             ctl_o,
  output logic              serr_o
);
  bctl_t ctl_q;
  bctl_t ctl_next;
  logic  serr_q;
  logic  any_disc;

  assign any_disc = |disc_i;

  always_comb begin
    ctl_next = wr_en_i ? (wdata_i & RW_MASK) : (ctl_q & RW_MASK);
    if (any_disc)                         ctl_next[BC_STATUS] = 1'b1;
    else if (wr_en_i && wdata_i[BC_STATUS]) ctl_next[BC_STATUS] = 1'b0;
    else                                  ctl_next[BC_STATUS] = ctl_q[BC_STATUS];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q  <= '0;
      serr_q <= 1'b0;
    end else begin
      ctl_q  <= ctl_next;
      serr_q <= any_disc && ctl_q[BC_SERR_EN];
    end
  end

  assign ctl_o  = ctl_q;
  assign serr_o = serr_q;

  // R7: any sampled discard leaves the flag set
  p_flag_set_r7: assert property (@(posedge clk) disable iff (rst)
    any_disc |=> ctl_q[BC_STATUS]);
  // R8: without a discard or a write of one, the flag holds
  p_flag_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!any_disc && !(wr_en_i && wdata_i[BC_STATUS])) |=> $stable(ctl_q[BC_STATUS]));
  // R8: a write of one with no discard clears the flag
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && wdata_i[BC_STATUS] && !any_disc) |=> !ctl_q[BC_STATUS]);
  // R9: with the enable clear no error request follows
  p_serr_gated_r9: assert property (@(posedge clk) disable iff (rst)
    !ctl_q[BC_SERR_EN] |=> !serr_o);
  // R9: an enabled timeout raises the error request
  p_serr_raised_r9: assert property (@(posedge clk) disable iff (rst)
    (any_disc && ctl_q[BC_SERR_EN]) |=> serr_o);
endmodule

// File: rtl/dtx_discard_ctl.sv
module dtx_discard_ctl #(
  parameter int LONG_LOG2  = 15,
  parameter int SHORT_LOG2 = 10
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr_i,
  input  logic [15:0] reg_wdata_i,
  output logic [15:0] reg_rdata_o,
  input  logic [1:0]  cpl_queued_i,
  input  logic [1:0]  cpl_claimed_i,
  output logic [1:0]  discard_o,
  output logic        serr_o
);
  import dtx_pkg::*;

  bctl_t             ctl;
  logic [NUM_IF-1:0] disc;

  dtx_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .wr_en_i (reg_wr_i),
    .wdata_i (reg_wdata_i),
    .disc_i  (disc),
    .ctl_o   (ctl),
    .serr_o  (serr_o)
  );

  for (genvar g = 0; g < NUM_IF; g++) begin : g_tmr
    dtx_timer #(
      .LONG_LOG2  (LONG_LOG2),
      .SHORT_LOG2 (SHORT_LOG2)
    ) u_tmr (
      .clk         (clk),
      .rst         (rst),
      .queued_i    (cpl_queued_i[g]),
      .claimed_i   (cpl_claimed_i[g]),
      .short_sel_i (ctl[BC_PRI_SHORT + g]),
      .discard_o   (disc[g])
    );
  end

  assign discard_o   = disc;
  assign reg_rdata_o = ctl;

  // R1: nothing is discarded in the first cycle after reset
  p_quiet_after_reset_r1: assert property (@(posedge clk)
    $fell(rst) |-> (discard_o == 2'b00 && !serr_o));
endmodule

// File: tb/dtx_discard_ctl_tb_top.sv
`timescale 1ns/1ps
module dtx_discard_ctl_tb_top;
  localparam int LL = 6;
  localparam int SL = 3;
  localparam int LN = 1 << LL;
  localparam int SN = 1 << SL;
  localparam int LIM = 2 * LN + 12;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [1:0]  queued = '0;
  logic [1:0]  claimed = '0;
  logic [1:0]  discard;
  logic        serr;

  int errors = 0;
  int checks = 0;
  int res_first [2];
  int res_pulses[2];
  int res_sfirst;
  int res_spulses;

  always #10 clk = ~clk;

  dtx_discard_ctl #(.LONG_LOG2(LL), .SHORT_LOG2(SL)) dut_i (
    .clk(clk), .rst(rst), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .cpl_queued_i(queued), .cpl_claimed_i(claimed),
    .discard_o(discard), .serr_o(serr));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic write_reg(input logic [15:0] v);
    reg_wr = 1'b1;
    reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  // queue on the edge after the call, then observe LIM edges
  task automatic run_case(input logic [1:0] qm, input logic [1:0] cm,
                          input int claim_at, input int rq_at,
                          input int wr_at, input logic [15:0] wr_val);
    for (int i = 0; i < 2; i++) begin res_first[i] = 0; res_pulses[i] = 0; end
    res_sfirst = 0; res_spulses = 0;
    queued = qm;
    @(negedge clk);
    queued = '0;
    for (int k = 1; k <= LIM; k++) begin
      if (k == claim_at) claimed = cm;
      if (k == rq_at) queued = qm;
      if (k == wr_at) begin reg_wr = 1'b1; reg_wdata = wr_val; end
      @(negedge clk);
      claimed = '0; queued = '0; reg_wr = 1'b0;
      for (int i = 0; i < 2; i++)
        if (discard[i]) begin
          res_pulses[i]++;
          if (res_first[i] == 0) res_first[i] = k;
        end
      if (serr) begin
        res_spulses++;
        if (res_sfirst == 0) res_sfirst = k;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] base;
    int n;
    bit exp_d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1 reset state and idle timers
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 discard", discard, 0);
    chk("R1 serr", serr, 0);
    run_case(2'b00, 2'b00, 0, 0, 0, 16'h0);
    chk("R1 idle pulses p", res_pulses[0], 0);
    chk("R1 idle pulses s", res_pulses[1], 0);

    // R10 storage sweep: walking and shifted patterns
    for (int s = 0; s < 16; s++) begin
      logic [15:0] v;
      v = (16'h0001 << s) & ~16'h0400;
      write_reg(v);
      chk("R10 walk", reg_rdata, int'(v & 16'h0BEF));
      v = 16'hA5C3 ^ (16'h1357 << s);
      v[10] = 1'b0;
      write_reg(v);
      chk("R10 mix", reg_rdata, int'(v & 16'h0BEF));
    end
    write_reg(16'hFFFF);
    chk("R10 all ones", reg_rdata, 16'h0BEF);
    write_reg(16'h0000);
    chk("R10 all zeros", reg_rdata, 0);

    // R2 R3 R4 R6 R7 R8 R9 sweep over interface, period and claim offset
    for (int idx = 0; idx < 2; idx++) begin
      for (int sel = 0; sel < 2; sel++) begin
        base = 16'h00A5 | (16'(sel) << (8 + idx)) | (16'(sel) << 11);
        n = sel ? SN : LN;
        write_reg(base);
        chk("R10 base", reg_rdata, int'(base));
        for (int ca = 0; ca <= n + 2; ca++) begin
          run_case(2'(1 << idx), 2'(1 << idx), ca, 0, 0, 16'h0);
          exp_d = (ca == 0) || (ca > n);
          chk("R4 R6 pulses", res_pulses[idx], exp_d ? 1 : 0);
          if (exp_d) chk(idx ? "R3 latency" : "R2 latency", res_first[idx], n);
          chk("R6 other idle", res_pulses[1 - idx], 0);
          chk("R9 serr pulses", res_spulses, (exp_d && sel) ? 1 : 0);
          if (exp_d && sel) chk("R9 serr timing", res_sfirst, n + 1);
          chk("R7 flag", reg_rdata[10], exp_d ? 1 : 0);
          if (exp_d) begin
            write_reg(base);
            chk("R8 write zero keeps", reg_rdata[10], 1);
          end
          write_reg(base | 16'h0400);
          chk("R8 write one clears", reg_rdata[10], 0);
        end
      end
    end

    // R5 restart on re-queue
    base = 16'h0300;
    write_reg(base);
    run_case(2'b01, 2'b00, 0, 5, 0, 16'h0);
    chk("R5 restart latency", res_first[0], 5 + SN);
    chk("R5 restart pulses", res_pulses[0], 1);
    write_reg(base | 16'h0400);

    // R11 period frozen at queue edge
    base = 16'h0000;
    write_reg(base);
    run_case(2'b01, 2'b00, 0, 0, 3, 16'h0100);
    chk("R11 frozen latency", res_first[0], LN);
    chk("R10 bit8 written", reg_rdata[8], 1);
    write_reg(16'h0400);

    // R8 clear write on the edge that samples a discard: flag stays set
    base = 16'h0300;
    write_reg(base);
    run_case(2'b10, 2'b00, 0, 0, SN + 1, base | 16'h0400);
    chk("R8 same-edge set wins", reg_rdata[10], 1);
    write_reg(base | 16'h0400);
    chk("R8 cleared after", reg_rdata[10], 0);

    // R9 simultaneous discards give one error pulse
    base = 16'h0B00;
    write_reg(base);
    run_case(2'b11, 2'b00, 0, 0, 0, 16'h0);
    chk("R3 both latency s", res_first[1], SN);
    chk("R2 both latency p", res_first[0], SN);
    chk("R9 single serr", res_spulses, 1);
    chk("R9 serr timing both", res_sfirst, SN + 1);
    write_reg(base | 16'h0400);

    // R9 enable clear: timeout without error request
    write_reg(16'h0100);
    run_case(2'b01, 2'b00, 0, 0, 0, 16'h0);
    chk("R9 gated", res_spulses, 0);
    chk("R7 gated flag", reg_rdata[10], 1);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule